// File: doc/BRIEF.md
# Sleep and Wake Controller

This block is the register-mapped front end of a chip's sleep logic. Software writes a control word to put the system to sleep and, separately, to ask for the video memory to be powered down. It then polls the same word until the memory status bit matches the request. The memory status follows the request after a fixed number of cycles, which stands in for an acknowledge from the power switch.

While the block is asleep it watches a vector of wake trigger inputs, filtered through a software-written enable mask. Only eight trigger positions exist: keypad interrupt, lid opened, headphone removed, wireless, lid GPIO line, microcontroller interrupt, touch press and cartridge change. The first cycle in which an enabled trigger is seen ends sleep. Every enabled trigger present in that cycle is latched into a reason register that has the same bit layout as the mask. A single interrupt line stays high until software has cleared every reason bit by writing ones to them.

Register offsets are byte addresses on a 4-bit address bus: control at 0x0, wake enable at 0x4 and wake reason at 0x8. Reads are combinational from the current address.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset, all three registers read 0, and sleepActive, memPowerDown and wakeIrq are low.
- R2: A write to the control register with bit 0 set while the block is awake puts it to sleep from the next cycle on. Control bit 0 reads 1 while asleep. A write with bit 0 clear does not change the sleep state.
- R3: All control register bits other than bit 0 and bit 15 read 0, whatever was written to them.
- R4: Control bit 15 written 1 requests memory power-down. Control bit 15 and the memPowerDown output become 1 exactly PD_LATENCY cycles (default 12) after the write edge. Writing bit 15 as 0 powers the memory back up with the same delay.
- R5: Only bits 1, 3, 4, 8, 19, 26, 30 and 31 of the wake-enable register (mask 0xC408011A) can be written. All other bits read 0.
- R6: While asleep, a trigger whose enable bit is set ends sleep at the next clock edge, and its reason bit (same position as the enable bit) is set at that edge.
- R7: A trigger whose enable bit is clear, or any trigger seen while the block is awake, neither sets a reason bit nor ends sleep.
- R8: Writing 1 to a reason bit clears it. Writing 0 leaves it unchanged.
- R9: wakeIrq is high exactly while at least one reason bit is set.
- R10: A read from any offset other than 0x0, 0x4 and 0x8 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 4 | Byte offset for reads and writes |
| regWrEn | input | 1 | Write strobe for the current offset |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for the current offset |
| wakeTrig | input | 32 | Wake trigger levels |
| sleepActive | output | 1 | High while the block is asleep |
| memPowerDown | output | 1 | Memory power-down status |
| wakeIrq | output | 1 | Shared wake interrupt |

## Verification
The hardest case to reach is a trigger arriving while the block is asleep but masked off, or arriving at a position that does not exist. Such a trigger must leave both the sleep state and the reason register untouched, so the block has to be put to sleep again and woken through a known position before the next probe. The stimulus sweeps one trigger bit at a time across all 32 positions, first with every enable bit written and then with a single enable bit. Each probe is followed by a recovery wake and a clear, and the expected outcome is taken from the implemented-position mask.

// File: rtl/sleepwake_pkg.sv
package sleepwake_pkg;
  localparam logic [3:0] CTRL_OFS   = 4'h0;
  localparam logic [3:0] ENABLE_OFS = 4'h4;
  localparam logic [3:0] REASON_OFS = 4'h8;

  typedef enum logic {
    SW_AWAKE  = 1'b0,
    SW_ASLEEP = 1'b1
  } swState_t;

  typedef struct packed {
    logic ctrlWr;
    logic enableWr;
    logic reasonWr;
    logic captureWake;
  } swStrobe_t;
endpackage

// File: rtl/swc_control.sv
module swc_control
  import sleepwake_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int PD_LATENCY = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              sleepReqBit,
  input  logic              pdReqBit,
  input  logic              wakeHitAny,
  output swStrobe_t         strobe,
  output logic              sleepActive,
  output logic              memPdStatus
);
  localparam int CNT_W = (PD_LATENCY > 2) ? $clog2(PD_LATENCY) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PD_LATENCY - 1);

  swState_t   stateQ, stateD;
  logic       pdTargetQ;
  logic [CNT_W-1:0] pdCntQ;

  // address decode into strobes for the datapath
  always_comb begin
    strobe.ctrlWr      = regWrEn && (regAddr == ADDR_W'(CTRL_OFS));
    strobe.enableWr    = regWrEn && (regAddr == ADDR_W'(ENABLE_OFS));
    strobe.reasonWr    = regWrEn && (regAddr == ADDR_W'(REASON_OFS));
    strobe.captureWake = (stateQ == SW_ASLEEP) && wakeHitAny;
  end

  // sleep state machine
  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      SW_AWAKE:  if (strobe.ctrlWr && sleepReqBit) stateD = SW_ASLEEP;
      SW_ASLEEP: if (wakeHitAny) stateD = SW_AWAKE;
      default:   stateD = SW_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= SW_AWAKE;
    else       stateQ <= stateD;
  end

  assign sleepActive = (stateQ == SW_ASLEEP);

  // memory power-down request / delayed acknowledge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdTargetQ   <= 1'b0;
      pdCntQ      <= '0;
      memPdStatus <= 1'b0;
    end else if (strobe.ctrlWr) begin
      pdTargetQ <= pdReqBit;
      pdCntQ    <= '0;
    end else if (pdTargetQ != memPdStatus) begin
      if (pdCntQ == CNT_LAST) begin
        memPdStatus <= pdTargetQ;
        pdCntQ      <= '0;
      end else begin
        pdCntQ <= pdCntQ + 1'b1;
      end
    end
  end
endmodule

// File: rtl/swc_datapath.sv
module swc_datapath
  import sleepwake_pkg::*;
#(
  parameter int          ADDR_W    = 4,
  parameter int          DATA_W    = 32,
  parameter logic [31:0] TRIG_IMPL = 32'hC408_011A
) (
  input  logic              clk,
  input  logic              rstN,
  input  swStrobe_t         strobe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] wakeTrig,
  input  logic              sleepActive,
  input  logic              memPdStatus,
  output logic              wakeHitAny,
  output logic [DATA_W-1:0] regRdData,
  output logic              wakeIrq
);
  localparam logic [DATA_W-1:0] IMPL_MASK = DATA_W'(TRIG_IMPL);

  logic [DATA_W-1:0] enableQ, reasonQ, reasonD, wakeHit, clearMask, ctrlView;

  assign wakeHit    = wakeTrig & enableQ & IMPL_MASK;
  assign wakeHitAny = |wakeHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               enableQ <= '0;
    else if (strobe.enableWr) enableQ <= regWrData & IMPL_MASK;
  end

  always_comb begin
    clearMask = strobe.reasonWr ? regWrData : '0;
    reasonD   = reasonQ & ~clearMask;
    if (strobe.captureWake) reasonD = reasonD | wakeHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reasonQ <= '0;
    else       reasonQ <= reasonD;
  end

  assign wakeIrq = |reasonQ;

  // control view: bit0 sleep state, bit15 memory status, rest zero
  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_ctrlView
      if (b == 0) begin : g_sleep
        assign ctrlView[b] = sleepActive;
      end else if (b == 15) begin : g_pd
        assign ctrlView[b] = memPdStatus;
      end else begin : g_zero
        assign ctrlView[b] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    unique case (regAddr)
      ADDR_W'(CTRL_OFS):   regRdData = ctrlView;
      ADDR_W'(ENABLE_OFS): regRdData = enableQ;
      ADDR_W'(REASON_OFS): regRdData = reasonQ;
      default:             regRdData = '0;
    endcase
  end
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import sleepwake_pkg::*;
#(
  parameter int          ADDR_W     = 4,
  parameter int          DATA_W     = 32,
  parameter int          PD_LATENCY = 12,
  parameter logic [31:0] TRIG_IMPL  = 32'hC408_011A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [DATA_W-1:0] wakeTrig,
  output logic              sleepActive,
  output logic              memPowerDown,
  output logic              wakeIrq
);
  swStrobe_t strobe;
  logic      wakeHitAny;

  swc_control #(.ADDR_W(ADDR_W), .PD_LATENCY(PD_LATENCY)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .sleepReqBit(regWrData[0]), .pdReqBit(regWrData[15]),
    .wakeHitAny(wakeHitAny), .strobe(strobe),
    .sleepActive(sleepActive), .memPdStatus(memPowerDown)
  );

  swc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TRIG_IMPL(TRIG_IMPL)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regAddr(regAddr),
    .regWrData(regWrData), .wakeTrig(wakeTrig), .sleepActive(sleepActive),
    .memPdStatus(memPowerDown), .wakeHitAny(wakeHitAny),
    .regRdData(regRdData), .wakeIrq(wakeIrq)
  );
endmodule

// File: rtl/swc_checker.sv
module swc_checker #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic              sleepActive,
  input logic              memPowerDown,
  input logic              wakeIrq
);
  logic ctrlWrite;
  assign ctrlWrite = regWrEn && (regAddr == ADDR_W'(4'h0));

  AST_SLEEP_ENTRY_BY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleepActive) |-> $past(ctrlWrite && regWrData[0])); // R2

  AST_CTRL_GAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(4'h0)) |-> (regRdData[14:1] == '0)); // R3

  AST_PD_NOT_IMMEDIATE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memPowerDown) |-> !$past(ctrlWrite)); // R4

  AST_WAKE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sleepActive) |-> wakeIrq); // R6

  AST_IRQ_ONLY_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeIrq) |-> $past(sleepActive)); // R7

  AST_FULL_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(4'h8) && (&regWrData) && !sleepActive) |=> !wakeIrq); // R8
endmodule

bind sleep_wake_ctrl swc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .regWrData(regWrData), .regRdData(regRdData), .sleepActive(sleepActive),
  .memPowerDown(memPowerDown), .wakeIrq(wakeIrq)
);

// File: tb/sleep_wake_ctrl_tb.sv
`timescale 1ns/1ps
module sleep_wake_ctrl_tb;
  localparam int          LAT  = 12;
  localparam logic [31:0] IMPL = 32'hC408_011A;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] wakeTrig = '0;
  logic        sleepActive, memPowerDown, wakeIrq;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  sleep_wake_ctrl #(.PD_LATENCY(LAT)) u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .wakeTrig(wakeTrig),
    .sleepActive(sleepActive), .memPowerDown(memPowerDown), .wakeIrq(wakeIrq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic pulseTrig(input logic [31:0] t);
    @(negedge clk);
    wakeTrig = t;
    @(negedge clk);
    wakeTrig = '0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      nFails++;
      $display("FAIL R1 watchdog actual=%0d expected=<100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regRead(4'h0, rd); chk("R1 ctrl", rd, 0);
    regRead(4'h4, rd); chk("R1 enable", rd, 0);
    regRead(4'h8, rd); chk("R1 reason", rd, 0);
    chk("R1 outputs", {29'b0, sleepActive, memPowerDown, wakeIrq}, 0);

    // R10 unused offsets
    for (int a = 0; a < 16; a++) begin
      if (a != 0 && a != 4 && a != 8) begin
        regRead(4'(a), rd); chk("R10 unused offset", rd, 0);
      end
    end

    // R5 enable writable mask
    regWrite(4'h4, 32'hFFFF_FFFF);
    regRead(4'h4, rd); chk("R5 enable all", rd, IMPL);
    regWrite(4'h4, ~IMPL);
    regRead(4'h4, rd); chk("R5 enable unimpl", rd, 0);

    // R3 gap bits, R2 write-0 no sleep
    regWrite(4'h0, 32'hFFFF_7FFE);
    regRead(4'h0, rd); chk("R3 ctrl gap", rd, 0);
    chk("R2 no sleep on bit0=0", {31'b0, sleepActive}, 0);

    // R4 power-down delay
    regWrite(4'h0, 32'h0000_8000);
    repeat (LAT - 1) @(negedge clk);
    regRead(4'h0, rd); chk("R4 pd before latency", rd, 0);
    chk("R4 pd pin before", {31'b0, memPowerDown}, 0);
    @(negedge clk);
    regRead(4'h0, rd); chk("R4 pd at latency", rd, 32'h8000);
    chk("R4 pd pin at", {31'b0, memPowerDown}, 1);
    regWrite(4'h0, 32'h0);
    repeat (LAT - 1) @(negedge clk);
    chk("R4 pu before latency", {31'b0, memPowerDown}, 1);
    @(negedge clk);
    regRead(4'h0, rd); chk("R4 pu at latency", rd, 0);

    // R7 triggers while awake ignored
    regWrite(4'h4, 32'hFFFF_FFFF);
    pulseTrig(32'hFFFF_FFFF);
    regRead(4'h8, rd); chk("R7 awake trig reason", rd, 0);
    chk("R7 awake trig irq", {31'b0, wakeIrq}, 0);

    // R6/R7/R8/R9 sweep, all enabled
    for (int i = 0; i < 32; i++) begin
      logic impl;
      impl = IMPL[i];
      regWrite(4'h0, 32'h1);
      regRead(4'h0, rd); chk("R2 asleep readback", rd, 1);
      pulseTrig(32'h1 << i);
      chk("R6 sleep exit", {31'b0, sleepActive}, {31'b0, !impl});
      regRead(4'h8, rd); chk("R6 reason bit", rd, impl ? (32'h1 << i) : 32'h0);
      chk("R9 irq", {31'b0, wakeIrq}, {31'b0, impl});
      if (!impl) begin
        pulseTrig(32'h2);
        regRead(4'h8, rd); chk("R6 recovery wake", rd, 32'h2);
      end
      regWrite(4'h8, 32'hFFFF_FFFF);
      regRead(4'h8, rd); chk("R8 clear all", rd, 0);
      chk("R9 irq low", {31'b0, wakeIrq}, 0);
    end

    // R7 single enable bit
    regWrite(4'h4, 32'h8);
    for (int j = 0; j < 32; j++) begin
      if (IMPL[j] && j != 3) begin
        regWrite(4'h0, 32'h1);
        pulseTrig(32'h1 << j);
        chk("R7 masked stays asleep", {31'b0, sleepActive}, 1);
        regRead(4'h8, rd); chk("R7 masked reason", rd, 0);
        pulseTrig((32'h1 << j) | 32'h8);
        regRead(4'h8, rd); chk("R7 only enabled latched", rd, 32'h8);
        regWrite(4'h8, 32'h8);
      end
    end

    // R8 partial clear, R9
    regWrite(4'h4, 32'hFFFF_FFFF);
    regWrite(4'h0, 32'h1);
    pulseTrig(32'h1A);
    regRead(4'h8, rd); chk("R6 multi capture", rd, 32'h1A);
    regWrite(4'h8, 32'h2);
    regRead(4'h8, rd); chk("R8 partial clear", rd, 32'h18);
    chk("R9 irq held", {31'b0, wakeIrq}, 1);
    regWrite(4'h8, 32'h0);
    regRead(4'h8, rd); chk("R8 zero write", rd, 32'h18);
    regWrite(4'h8, 32'h18);
    regRead(4'h8, rd); chk("R8 final clear", rd, 0);
    chk("R9 irq dropped", {31'b0, wakeIrq}, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule